// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This unit watches a group of external interrupt pins, eight by default, and turns activity on each one into an active-high level request for a downstream interrupt controller. Each pin first passes through a two-stage synchronizer. A two-bit sense code chosen per pin then decides what counts as an event: the pin being held low, a falling edge, a rising edge, or either edge.

In the edge modes, a detected event sets a sticky status bit. The bit holds until software clears it by writing zero to that bit position in the status register. In the low-level mode the status bit simply reports the inverted synchronized pin, and clearing writes are ignored. The request output for each pin always equals that pin's status bit.

A plain 32-bit register port reaches the status and sense-select registers. Reads are combinational from the address. Writes take effect at the clock edge. A read issued after a clearing write therefore already shows the cleared value.

Top module: `eirq_sense_unit`

## Requirements
- R1: After reset, all sense fields read 0 (low-level mode), the status register reads 0 while the pins are high, and every request is low.
- R2: The sense-select register at byte offset 0x14 holds a 2-bit field for pin n at bits [2n+1:2n] (codes: 0 low level, 1 falling edge, 2 rising edge, 3 both edges). Bits 31:16 read as 0 and cannot be written.
- R3: In low-level mode (code 0), the status bit and request of a pin equal the inverted pin value as it stands two clock edges earlier, and they drop again once the pin returns high.
- R4: In falling mode (code 1), a high-to-low transition sets the status bit. A low-to-high transition does not set it. The bit stays set after the pin returns high.
- R5: In rising mode (code 2), only a low-to-high transition sets the status bit.
- R6: In both-edges mode (code 3), either transition sets the status bit.
- R7: Writing 0 to bit n of the status register at byte offset 0x10 clears bit n when pin n is in an edge mode. Writing 1 leaves a bit unchanged and never sets it.
- R8: A clearing write to a pin in low-level mode has no effect on its status or request.
- R9: When an edge detection and a clearing write for the same pin fall in the same cycle, the status bit ends up set.
- R10: Request bit n always equals status bit n as read from offset 0x10.
- R11: An edge-mode request rises at the third rising clock edge after the pin change, and not before.
- R12: Offsets other than 0x10 and 0x14 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Asynchronous external interrupt pins |
| reg_addr | input | 8 | Register byte address |
| reg_wen | input | 1 | Write strobe, sampled at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| req_o | output | 8 | Active-high level request per pin |

## Verification
The directed tests separate the four sense codes from one another. Each edge mode is given the transition it must ignore as well as the one it must catch, and low-level mode is shown to follow the pin and to ignore clears. Two single-cycle probes are timed exactly: one pins the request to the third clock edge after a pin change, and one lands a clearing write in the same cycle as a detection to show that the detection wins. A long random phase then toggles pins, rewrites sense codes and issues clears and stray writes in every combination. It compares every request and every register read against a cycle model built from the requirements, which exposes mode changes in the middle of an event and clears that arrive while a pin is moving.

// File: rtl/eirq_pkg.sv
// Shared types and constants for the external pin interrupt sense unit.
// Assumes byte addressing on the register port.
package eirq_pkg;

    // Per-pin sense selection; the code values are software visible.
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'd0,
        SENSE_FALL = 2'd1,
        SENSE_RISE = 2'd2,
        SENSE_BOTH = 2'd3
    } sense_e;

    localparam int STAT_OFS = 'h10;
    localparam int MODE_OFS = 'h14;
    localparam int SENSE_W  = 2;

endpackage

// File: rtl/eirq_sync.sv
// Two-stage synchronizer for a bus of independent asynchronous pins.
// Assumes pins idle high, so both stages reset to 1 to avoid a false
// falling edge when reset is released.
module eirq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Two back-to-back flops per pin.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b1;
                sync_q[i] <= 1'b1;
            end else begin
                meta_q[i] <= async_i[i];
                sync_q[i] <= meta_q[i];
            end
        end
    end

    assign sync_o = sync_q;

    // R3
    sync_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sync_q == $past(meta_q)));

endmodule

// File: rtl/eirq_channel.sv
// One pin's detection and status state. It compares the synchronized
// sample with the sample from the previous cycle to find edges, keeps a
// sticky status flop for the edge modes, and reports the inverted sample
// directly in low-level mode. Assumes clr_i is a single-cycle pulse.
module eirq_channel
    import eirq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   smp_i,
    input  sense_e sense_i,
    input  logic   clr_i,
    output logic   stat_o
);

    logic prev_q;
    logic stat_q;
    logic fell;
    logic rose;
    logic det;

    // Keep the previous synchronized sample for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= smp_i;
    end

    assign fell = prev_q & ~smp_i;
    assign rose = ~prev_q & smp_i;

    // Pick the edge that counts for the current sense code.
    always_comb begin
        unique case (sense_i)
            SENSE_FALL: det = fell;
            SENSE_RISE: det = rose;
            SENSE_BOTH: det = fell | rose;
            default:    det = 1'b0;
        endcase
    end

    // Sticky status: detection over clear; held at zero in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                    stat_q <= 1'b0;
        else if (sense_i == SENSE_LOW) stat_q <= 1'b0;
        else if (det)                  stat_q <= 1'b1;
        else if (clr_i)                stat_q <= 1'b0;
    end

    assign stat_o = (sense_i == SENSE_LOW) ? ~smp_i : stat_q;

    // R4
    set_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> $past(smp_i != prev_q));

    // R7
    hold_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q && !clr_i && sense_i != SENSE_LOW) |=> stat_q);

    // R8
    level_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_i == SENSE_LOW) |=> !stat_q);

    // R9
    detect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && sense_i == SENSE_BOTH && smp_i != prev_q) |=> stat_q);

endmodule

// File: rtl/eirq_regs.sv
// Register decode: holds the sense-select register, turns writes of zero
// to the status offset into per-pin clear pulses, and muxes read data.
// Assumes DATA_W exceeds SENSE_W*NUM_PINS.
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr_i,
    input  logic                          wen_i,
    input  logic [DATA_W-1:0]             wdata_i,
    input  logic [NUM_PINS-1:0]           stat_i,
    output logic [DATA_W-1:0]             rdata_o,
    output logic [SENSE_W*NUM_PINS-1:0]   mode_o,
    output logic [NUM_PINS-1:0]           clr_o
);

    localparam int MODE_BITS = SENSE_W * NUM_PINS;

    logic [MODE_BITS-1:0] mode_q;
    logic                 hit_stat;
    logic                 hit_mode;
    logic                 unused_hi;

    assign hit_stat  = (addr_i == ADDR_W'(STAT_OFS));
    assign hit_mode  = (addr_i == ADDR_W'(MODE_OFS));
    assign unused_hi = ^wdata_i[DATA_W-1:MODE_BITS];

    // Sense-select register update.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= '0;
        else if (wen_i && hit_mode) mode_q <= wdata_i[MODE_BITS-1:0];
    end

    // Clear pulse per pin where a zero is written to the status offset.
    always_comb begin
        clr_o = '0;
        if (wen_i && hit_stat) clr_o = ~wdata_i[NUM_PINS-1:0];
    end

    // Read mux; unmapped offsets return zero.
    always_comb begin
        rdata_o = '0;
        if (hit_stat)      rdata_o[NUM_PINS-1:0]  = stat_i;
        else if (hit_mode) rdata_o[MODE_BITS-1:0] = mode_q;
    end

    assign mode_o = mode_q;

    // R2
    mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wen_i && hit_mode) |=> $stable(mode_q));

    // R12
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_stat && !hit_mode) |-> (rdata_o == '0));

endmodule

// File: rtl/eirq_sense_unit.sv
// Top of the external pin interrupt sense unit: synchronizer, register
// decode, and one detection channel per pin. Each request output is the
// pin's status bit. Assumes a single clock domain for the register port.
module eirq_sense_unit
    import eirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic                reg_wen,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_PINS-1:0] req_o
);

    localparam int MODE_BITS = SENSE_W * NUM_PINS;

    logic [NUM_PINS-1:0]  smp;
    logic [NUM_PINS-1:0]  clr;
    logic [NUM_PINS-1:0]  stat;
    logic [MODE_BITS-1:0] mode;

    eirq_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (smp)
    );

    eirq_regs #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr),
        .wen_i   (reg_wen),
        .wdata_i (reg_wdata),
        .stat_i  (stat),
        .rdata_o (reg_rdata),
        .mode_o  (mode),
        .clr_o   (clr)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_chan
        eirq_channel u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .smp_i   (smp[n]),
            .sense_i (sense_e'(mode[SENSE_W*n +: SENSE_W])),
            .clr_i   (clr[n]),
            .stat_o  (stat[n])
        );
    end

    assign req_o = stat;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (mode == '0));

endmodule

// File: tb/eirq_sense_unit_tb.sv
module eirq_sense_unit_tb;

    localparam int NP = 8;
    localparam logic [7:0] A_STAT = 8'h10;
    localparam logic [7:0] A_MODE = 8'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin = '1;
    logic [7:0]    reg_addr = 8'h00;
    logic          reg_wen = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] req;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    eirq_sense_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin),
        .reg_addr  (reg_addr),
        .reg_wen   (reg_wen),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .req_o     (req)
    );

    // Cycle model from the requirements: two sync stages, previous
    // sample, sticky status with detection over clear.
    logic [NP-1:0] m_s1, m_s2, m_prev, m_stat;
    logic [15:0]   m_mode;

    always @(posedge clk) begin
        logic [NP-1:0] nstat;
        logic [1:0]    sn;
        logic          det;
        if (!rst_n) begin
            m_s1 = '1; m_s2 = '1; m_prev = '1; m_stat = '0; m_mode = '0;
        end else begin
            for (int n = 0; n < NP; n++) begin
                sn  = m_mode[2*n +: 2];
                det = (sn == 2'd1 && m_prev[n] && !m_s2[n]) ||
                      (sn == 2'd2 && !m_prev[n] && m_s2[n]) ||
                      (sn == 2'd3 && (m_prev[n] != m_s2[n]));
                if (sn == 2'd0) nstat[n] = 1'b0;
                else if (det)   nstat[n] = 1'b1;
                else if (reg_wen && reg_addr == A_STAT && !reg_wdata[n]) nstat[n] = 1'b0;
                else            nstat[n] = m_stat[n];
            end
            m_stat = nstat;
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = pin;
            if (reg_wen && reg_addr == A_MODE) m_mode = reg_wdata[15:0];
        end
    end

    function automatic logic [NP-1:0] exp_status();
        logic [NP-1:0] r;
        for (int n = 0; n < NP; n++)
            r[n] = (m_mode[2*n +: 2] == 2'd0) ? ~m_s2[n] : m_stat[n];
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == A_STAT) return {24'h0, exp_status()};
        if (a == A_MODE) return {16'h0, m_mode};
        return 32'h0;
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    task automatic step(input int k = 1);
        for (int i = 0; i < k; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
        step();
        reg_wen = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        step(4);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk("R1 req", {24'h0, req}, 32'h0);
        rd(A_MODE, d); chk("R1 mode", d, 32'h0);
        rd(A_STAT, d); chk("R1 stat", d, 32'h0);

        // R3 level-low follows pin with two-edge latency
        pin[0] = 1'b0;
        step(); chk("R3 early", {24'h0, req}, 32'h0);
        step(); chk("R3 level", {24'h0, req}, 32'h1);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R8 clear ignored", d, 32'h1);
        pin[0] = 1'b1;
        step(2); chk("R3 release", {24'h0, req}, 32'h0);

        // R2 field layout, upper bits not stored
        wr(A_MODE, 32'hABCD_1B6C);
        rd(A_MODE, d); chk("R2 readback", d, 32'h0000_1B6C);
        wr(A_MODE, 32'h0000_0039); // pin0 fall, pin1 rise, pin2 both
        rd(A_STAT, d); chk("R2 stat quiet", d, 32'h0);

        // R4 / R11 falling edge
        pin[0] = 1'b0;
        step(2); chk("R11 not yet", {24'h0, req}, 32'h0);
        step();  chk("R11 third edge", {24'h0, req}, 32'h1);
        pin[0] = 1'b1;
        step(4); chk("R4 held, rise ignored", {24'h0, req}, 32'h1);

        // R5 rising edge
        pin[1] = 1'b0;
        step(4); chk("R5 fall ignored", {24'h0, req}, 32'h1);
        pin[1] = 1'b1;
        step(4); chk("R5 rise sets", {24'h0, req}, 32'h3);

        // R7 clear by zero, ones never set
        wr(A_STAT, 32'hFFFF_FFFE);
        rd(A_STAT, d); chk("R7 clear bit0", d, 32'h2);
        chk("R10 req matches", {24'h0, req}, d);
        wr(A_STAT, 32'hFFFF_FFFF);
        rd(A_STAT, d); chk("R7 ones no set", d, 32'h2);

        // R6 both edges
        pin[2] = 1'b0;
        step(4); chk("R6 fall", {24'h0, req}, 32'h6);
        wr(A_STAT, 32'hFFFF_FFFB);
        rd(A_STAT, d); chk("R7 clear bit2", d, 32'h2);
        pin[2] = 1'b1;
        step(4); chk("R6 rise", {24'h0, req}, 32'h6);

        // R9 detection in same cycle as clear
        pin[2] = 1'b0;
        step(2);
        wr(A_STAT, 32'hFFFF_FFFB);
        chk("R9 detect wins", {24'h0, req}, 32'h6);
        wr(A_STAT, 32'hFFFF_FFFB);
        chk("R9 later clear", {24'h0, req}, 32'h2);

        // R12 unmapped offset
        wr(8'h18, 32'h0);
        rd(A_MODE, d); chk("R12 mode kept", d, 32'h39);
        rd(8'h18, d);  chk("R12 reads zero", d, 32'h0);
        chk("R12 status kept", {24'h0, req}, 32'h2);

        // Random phase against the cycle model
        for (int it = 0; it < 4000; it++) begin
            chk("R10 random req", {24'h0, req}, {24'h0, exp_status()});
            #1;
            chk("R2 R3 R7 random read", reg_rdata, exp_read(reg_addr));
            for (int n = 0; n < NP; n++)
                if ($urandom_range(7) == 0) pin[n] = ~pin[n];
            case ($urandom_range(2))
                0: reg_addr = A_STAT;
                1: reg_addr = A_MODE;
                default: reg_addr = 8'h18;
            endcase
            reg_wen   = ($urandom_range(3) == 0);
            reg_wdata = $urandom();
            step();
        end
        reg_wen = 1'b0;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule